// File: doc/BRIEF.md
# Power-up Reset Time-out Sequencer

This block keeps a device in reset after a power-on event, a qualified supply brown-out or a wake from sleep. It releases reset only when a series of staged time-outs has run. The first stage is a power-up delay, counted in ticks of a slow internal timing oscillator. The second stage is an oscillator start-up count, counted in cycles of the main oscillator clock. The external active-low reset pin can keep the chip in reset after both timers have expired. Once the pin is sampled high, reset releases on that same clock edge.

Brown-out detection is qualified. The synchronized supply-low flag must stay set for a set number of slow ticks before the block treats it as a brown-out. A brown-out holds reset while the supply stays low, and then the full power-up delay runs with no oscillator start-up count. A stage output reports where the sequencer is, so that stage ordering can be checked from outside.

The whole block runs on the main oscillator clock. The power-on event acts as its asynchronous reset. The slow-oscillator tick is a single-cycle pulse already synchronized to that clock.

Top module: `rst_seq_top`

## Requirements
- R1: While `por_evt` is high, and on the first cycle after it falls, `chip_rst` is 1 and `stage_o` shows the power-up delay stage.
- R2: When the power-up delay runs, the sequencer leaves that stage on the clock edge that samples the `PWRT_TICKS`-th `slow_tick` seen in the stage. Earlier ticks do not end it.
- R3: With `cfg_pwrt_en` and `cfg_bor_en` both 0, the power-up delay is skipped. The stage is left on the first edge, with no tick consumed.
- R4: After a power-on event, in oscillator modes 0, 1 and 2 (low-power crystal, crystal, high-speed crystal), the start-up stage lasts exactly `OST_CYCLES` clock cycles and then releases.
- R5: In oscillator mode 3 (RC / external clock), the start-up stage never runs.
- R6: With `cfg_bor_en` set, `vdd_low` held for `BOR_TICKS` consecutive slow ticks enters the brown-out hold stage on the edge of the last tick. A dip covering fewer ticks, or any dip with `cfg_bor_en` at 0, leaves the running chip untouched.
- R7: The brown-out hold stage lasts as long as `vdd_low` is 1. When the supply recovers, a full power-up delay runs and reset releases without an oscillator start-up count.
- R8: If `vdd_low` rises during the power-up delay while brown-out is enabled, the next edge returns to brown-out hold. After recovery the delay restarts from zero.
- R9: With `cfg_bor_en` set, the power-up delay runs even when `cfg_pwrt_en` is 0.
- R10: If `ext_rst_n` is low when the timers finish, the sequencer waits in the pin stage. It goes to run on the edge that samples the pin high.
- R11: A low `ext_rst_n` does not change the length of a running delay or start-up count. Pulling it low while running enters the pin stage on the next edge, with no start-up count afterwards.
- R12: `wake_req` while running starts an oscillator start-up count of `OST_CYCLES` cycles in modes 0 to 2. In mode 3 it is ignored.
- R13: `stage_o` encodes 0 brown-out hold, 1 power-up delay, 2 oscillator start-up, 3 pin wait and 4 running. `chip_rst` is 1 in every stage except running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Main oscillator clock |
| por_evt | input | 1 | Power-on event, asynchronous active-high reset of the sequencer |
| vdd_low | input | 1 | Synchronized supply-below-threshold flag |
| slow_tick | input | 1 | One-cycle tick from the slow timing oscillator |
| ext_rst_n | input | 1 | External reset pin, active low, already filtered |
| wake_req | input | 1 | Wake-from-sleep request |
| cfg_pwrt_en | input | 1 | Power-up delay enable |
| cfg_bor_en | input | 1 | Brown-out detection enable |
| cfg_osc_mode | input | 2 | Oscillator mode: 0, 1, 2 crystal types, 3 RC |
| chip_rst | output | 1 | Chip reset, active high |
| stage_o | output | 3 | Current sequencer stage |

## Verification
The assertions watch the local stage transitions on every cycle. They cover the exit from brown-out hold into the power-up delay, the return to hold on a supply dip during the delay, the ban on a start-up count after a brown-out, entry to and release from the pin stage, start-up only in crystal modes, and the counter bounds. Exact stage lengths measured in ticks and cycles cannot be seen from a single cycle. Neither can the rejection of short or disabled dips, nor the full restart of the delay after a dip. The bench scenarios show these by counting ticks and cycles across each stage.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [2:0] {
    STG_BROWN = 3'd0,
    STG_PWRUP = 3'd1,
    STG_OSCST = 3'd2,
    STG_PINW  = 3'd3,
    STG_RUN   = 3'd4
  } stage_e;

  localparam logic [1:0] OSC_LP = 2'd0;
  localparam logic [1:0] OSC_XT = 2'd1;
  localparam logic [1:0] OSC_HS = 2'd2;
  localparam logic [1:0] OSC_RC = 2'd3;

  // crystal-type modes need a start-up count
  function automatic logic osc_needs_startup(input logic [1:0] mode);
    return (mode == OSC_LP) || (mode == OSC_XT) || (mode == OSC_HS);
  endfunction

  // brown-out enable forces the power-up delay on
  function automatic logic pwrt_active(input logic pwrt_en, input logic bor_en);
    return pwrt_en | bor_en;
  endfunction

  // where the sequence goes once all timers are done
  function automatic stage_e release_stage(input logic pin_n);
    return pin_n ? STG_RUN : STG_PINW;
  endfunction

endpackage

// File: rtl/rsq_counter.sv
module rsq_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic arst,
  input  logic clr,
  input  logic inc,
  output logic done
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;
  logic         at_last;

  assign at_last = (cnt == LAST);
  assign done    = inc & at_last & ~clr;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)          cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (inc)      cnt <= at_last ? '0 : cnt + 1'b1;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (arst)
    cnt <= LAST);

  // R2
  done_wrap_chk: assert property (@(posedge clk) disable iff (arst)
    done |=> (cnt == '0));

endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
  import rsq_pkg::*;
(
  input  logic       clk,
  input  logic       arst,
  input  logic       pwrt_en,
  input  logic       bor_en,
  input  logic [1:0] osc_mode,
  input  logic       vdd_low,
  input  logic       bor_trip,
  input  logic       pwrt_done,
  input  logic       ost_done,
  input  logic       ext_rst_n,
  input  logic       wake_req,
  output stage_e     stage,
  output logic       in_pwrt,
  output logic       in_ost
);
  stage_e nxt;
  logic   from_bor, nxt_bor;
  logic   need_ost;

  assign need_ost = osc_needs_startup(osc_mode);
  assign in_pwrt  = (stage == STG_PWRUP);
  assign in_ost   = (stage == STG_OSCST);

  always_comb begin
    nxt     = stage;
    nxt_bor = from_bor;
    unique case (stage)
      STG_BROWN: if (!vdd_low) nxt = STG_PWRUP;
      STG_PWRUP: begin
        if (bor_en && vdd_low) begin
          nxt     = STG_BROWN;
          nxt_bor = 1'b1;
        end else if (!pwrt_active(pwrt_en, bor_en) || pwrt_done) begin
          nxt = (!from_bor && need_ost) ? STG_OSCST : release_stage(ext_rst_n);
        end
      end
      STG_OSCST: if (ost_done) nxt = release_stage(ext_rst_n);
      STG_PINW:  if (ext_rst_n) nxt = STG_RUN;
      STG_RUN: begin
        if (!ext_rst_n) nxt = STG_PINW;
        else if (wake_req && need_ost) begin
          nxt     = STG_OSCST;
          nxt_bor = 1'b0;
        end
      end
      default:   nxt = STG_PWRUP;
    endcase
    if (bor_trip && stage != STG_PWRUP && stage != STG_BROWN) begin
      nxt     = STG_BROWN;
      nxt_bor = 1'b1;
    end
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      stage    <= STG_PWRUP;
      from_bor <= 1'b0;
    end else begin
      stage    <= nxt;
      from_bor <= nxt_bor;
    end
  end

  // R7
  brown_exit_chk: assert property (@(posedge clk) disable iff (arst)
    (stage == STG_BROWN && !vdd_low) |=> (stage == STG_PWRUP));

  // R8
  pwrt_dip_chk: assert property (@(posedge clk) disable iff (arst)
    (stage == STG_PWRUP && bor_en && vdd_low) |=> (stage == STG_BROWN));

  // R7
  bor_no_ost_chk: assert property (@(posedge clk) disable iff (arst)
    (stage == STG_PWRUP && from_bor) |=> (stage != STG_OSCST));

  // R11
  pin_entry_chk: assert property (@(posedge clk) disable iff (arst)
    (stage == STG_RUN && !ext_rst_n && !bor_trip) |=> (stage == STG_PINW));

  // R10
  pin_release_chk: assert property (@(posedge clk) disable iff (arst)
    (stage == STG_PINW && ext_rst_n && !bor_trip) |=> (stage == STG_RUN));

  // R5
  ost_mode_chk: assert property (@(posedge clk) disable iff (arst)
    (stage != STG_OSCST && !bor_trip) ##1 (stage == STG_OSCST) |-> need_ost);

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rsq_pkg::*;
#(
  parameter int PWRT_TICKS = 72,
  parameter int BOR_TICKS  = 2,
  parameter int OST_CYCLES = 1024
) (
  input  logic       osc_clk,
  input  logic       por_evt,
  input  logic       vdd_low,
  input  logic       slow_tick,
  input  logic       ext_rst_n,
  input  logic       wake_req,
  input  logic       cfg_pwrt_en,
  input  logic       cfg_bor_en,
  input  logic [1:0] cfg_osc_mode,
  output logic       chip_rst,
  output logic [2:0] stage_o
);
  stage_e stage;
  logic   in_pwrt, in_ost;
  logic   bor_trip, pwrt_done, ost_done;
  logic   bor_watch;

  assign bor_watch = vdd_low & cfg_bor_en;

  rsq_counter #(.LIMIT(BOR_TICKS)) u_bor_qual (
    .clk(osc_clk), .arst(por_evt), .clr(~bor_watch), .inc(slow_tick), .done(bor_trip)
  );

  rsq_counter #(.LIMIT(PWRT_TICKS)) u_pwrt (
    .clk(osc_clk), .arst(por_evt), .clr(~in_pwrt), .inc(slow_tick), .done(pwrt_done)
  );

  rsq_counter #(.LIMIT(OST_CYCLES)) u_ost (
    .clk(osc_clk), .arst(por_evt), .clr(~in_ost), .inc(1'b1), .done(ost_done)
  );

  rsq_fsm u_fsm (
    .clk(osc_clk), .arst(por_evt), .pwrt_en(cfg_pwrt_en), .bor_en(cfg_bor_en),
    .osc_mode(cfg_osc_mode), .vdd_low(vdd_low), .bor_trip(bor_trip),
    .pwrt_done(pwrt_done), .ost_done(ost_done), .ext_rst_n(ext_rst_n),
    .wake_req(wake_req), .stage(stage), .in_pwrt(in_pwrt), .in_ost(in_ost)
  );

  assign chip_rst = (stage != STG_RUN);
  assign stage_o  = stage;

  // R6
  bor_trip_src_chk: assert property (@(posedge osc_clk) disable iff (por_evt)
    bor_trip |-> (vdd_low && cfg_bor_en && slow_tick));

  // R13
  stage_legal_chk: assert property (@(posedge osc_clk) disable iff (por_evt)
    stage_o <= 3'd4);

endmodule

// File: tb/rst_seq_top_bench.sv
module rst_seq_top_bench;
  localparam int P = 5, B = 3, O = 16;
  // R13 stage encodings
  localparam int S_BROWN = 0, S_PWRUP = 1, S_OSCST = 2, S_PINW = 3, S_RUN = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic por_evt = 1'b1, vdd_low = 1'b0, slow_tick = 1'b0, ext_rst_n = 1'b1;
  logic wake_req = 1'b0, cfg_pwrt_en = 1'b0, cfg_bor_en = 1'b0;
  logic [1:0] cfg_osc_mode = 2'd0;
  logic chip_rst;
  logic [2:0] stage_o;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  rst_seq_top #(.PWRT_TICKS(P), .BOR_TICKS(B), .OST_CYCLES(O)) u_rst_seq_top (
    .osc_clk(clk), .por_evt(por_evt), .vdd_low(vdd_low), .slow_tick(slow_tick),
    .ext_rst_n(ext_rst_n), .wake_req(wake_req), .cfg_pwrt_en(cfg_pwrt_en),
    .cfg_bor_en(cfg_bor_en), .cfg_osc_mode(cfg_osc_mode),
    .chip_rst(chip_rst), .stage_o(stage_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      checks++; fails++;
      $display("FAIL R13 watchdog actual=%0d expected=%0d", cycles, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic power_on(input bit pe, input bit be, input int m);
    cfg_pwrt_en = pe; cfg_bor_en = be; cfg_osc_mode = 2'(m);
    por_evt = 1'b1; slow_tick = 1'b0;
    cyc(); cyc();
    chk(chip_rst == 1'b1, "R1 rst during por", chip_rst, 1);
    chk(stage_o == S_PWRUP, "R1 stage during por", stage_o, S_PWRUP);
    por_evt = 1'b0;
  endtask

  // runs until running or pin wait; counts ticks in delay and cycles in start-up
  task automatic run_seq(input int exp_t, input int exp_o, input string tag);
    int nt = 0, no = 0, mm = 0, k = 0;
    while (k < 3000 && stage_o != S_RUN && stage_o != S_PINW) begin
      bit t = (k % 3 == 2);
      if (stage_o == S_PWRUP && t) nt++;
      if (stage_o == S_OSCST) no++;
      if (chip_rst != (stage_o != S_RUN)) mm++;
      slow_tick = t;
      cyc();
      k++;
    end
    slow_tick = 1'b0;
    chk(nt == exp_t, {tag, " R2 delay ticks"}, nt, exp_t);
    chk(no == exp_o, {tag, " R4 startup cycles"}, no, exp_o);
    chk(mm == 0, {tag, " R13 rst vs stage"}, mm, 0);
  endtask

  // drives supply low with ticks until brown-out hold; returns ticks used
  task automatic trip_bor(output int n);
    n = 0;
    vdd_low = 1'b1;
    for (int i = 0; i < 200 && stage_o != S_BROWN; i++) begin
      bit t = (i % 3 == 2);
      if (t) n++;
      slow_tick = t;
      cyc();
    end
    slow_tick = 1'b0;
  endtask

  initial begin
    int n;
    bit ok;
    // R2 R3 R4 R5 R9 sweep over all configurations
    for (int pe = 0; pe < 2; pe++)
      for (int be = 0; be < 2; be++)
        for (int m = 0; m < 4; m++) begin
          power_on(pe[0], be[0], m);
          run_seq((pe != 0 || be != 0) ? P : 0, (m != 3) ? O : 0, "R3 R5 R9 sweep");
          chk(stage_o == S_RUN, "R4 final stage", stage_o, S_RUN);
          chk(chip_rst == 1'b0, "R13 released", chip_rst, 0);
        end

    // brown-out scenarios
    power_on(1'b0, 1'b1, 0);
    run_seq(P, O, "R9 bor start");
    vdd_low = 1'b1; ok = 1;
    for (int i = 0; i < 3 * (B - 1); i++) begin
      slow_tick = (i % 3 == 2); cyc(); if (stage_o != S_RUN) ok = 0;
    end
    slow_tick = 1'b0; vdd_low = 1'b0; cyc();
    chk(ok && stage_o == S_RUN, "R6 short dip ignored", stage_o, S_RUN);

    cfg_bor_en = 1'b0; vdd_low = 1'b1; ok = 1;
    for (int i = 0; i < 3 * (B + 3); i++) begin
      slow_tick = (i % 3 == 2); cyc(); if (stage_o != S_RUN) ok = 0;
    end
    slow_tick = 1'b0; vdd_low = 1'b0; cyc(); cfg_bor_en = 1'b1;
    chk(ok && stage_o == S_RUN, "R6 disabled dip ignored", stage_o, S_RUN);

    trip_bor(n);
    chk(n == B, "R6 qualification ticks", n, B);
    chk(chip_rst == 1'b1, "R13 rst in hold", chip_rst, 1);
    ok = 1;
    for (int i = 0; i < 12; i++) begin
      slow_tick = (i % 3 == 2); cyc(); if (stage_o != S_BROWN) ok = 0;
    end
    slow_tick = 1'b0;
    chk(ok, "R7 hold while low", stage_o, S_BROWN);
    vdd_low = 1'b0; cyc();
    chk(stage_o == S_PWRUP, "R7 recovery to delay", stage_o, S_PWRUP);
    run_seq(P, 0, "R7 after bor");
    chk(stage_o == S_RUN, "R7 release", stage_o, S_RUN);

    trip_bor(n);
    vdd_low = 1'b0; cyc();
    for (int i = 0; i < 6; i++) begin
      slow_tick = (i % 3 == 2); cyc();
    end
    slow_tick = 1'b0;
    chk(stage_o == S_PWRUP, "R8 mid delay", stage_o, S_PWRUP);
    vdd_low = 1'b1; cyc();
    chk(stage_o == S_BROWN, "R8 dip returns to hold", stage_o, S_BROWN);
    vdd_low = 1'b0; cyc();
    run_seq(P, 0, "R8 full restart");
    chk(stage_o == S_RUN, "R8 release", stage_o, S_RUN);

    // pin held low across timers
    ext_rst_n = 1'b0;
    power_on(1'b1, 1'b0, 3);
    run_seq(P, 0, "R11 pin low delay");
    chk(stage_o == S_PINW, "R10 waits on pin", stage_o, S_PINW);
    ok = 1;
    for (int i = 0; i < 10; i++) begin
      slow_tick = (i % 3 == 2); cyc(); if (stage_o != S_PINW || !chip_rst) ok = 0;
    end
    slow_tick = 1'b0;
    chk(ok, "R10 stays in pin wait", stage_o, S_PINW);
    ext_rst_n = 1'b1; cyc();
    chk(stage_o == S_RUN && chip_rst == 1'b0, "R10 release same edge", stage_o, S_RUN);

    ext_rst_n = 1'b0;
    power_on(1'b0, 1'b0, 1);
    run_seq(0, O, "R11 pin low startup");
    chk(stage_o == S_PINW, "R11 pin wait after startup", stage_o, S_PINW);
    ext_rst_n = 1'b1; cyc();
    chk(stage_o == S_RUN, "R10 release after startup", stage_o, S_RUN);

    ext_rst_n = 1'b0; cyc();
    chk(stage_o == S_PINW && chip_rst == 1'b1, "R11 pin reset entry", stage_o, S_PINW);
    for (int i = 0; i < 5; i++) cyc();
    ext_rst_n = 1'b1; cyc();
    chk(stage_o == S_RUN, "R11 pin reset release no startup", stage_o, S_RUN);

    // wake from sleep
    wake_req = 1'b1; cyc(); wake_req = 1'b0;
    chk(stage_o == S_OSCST, "R12 wake starts count", stage_o, S_OSCST);
    run_seq(0, O, "R12 wake");
    chk(stage_o == S_RUN, "R12 wake release", stage_o, S_RUN);
    cfg_osc_mode = 2'd3;
    wake_req = 1'b1; cyc(); wake_req = 1'b0; ok = 1;
    for (int i = 0; i < 5; i++) begin
      if (stage_o != S_RUN) ok = 0;
      cyc();
    end
    chk(ok, "R12 wake ignored in RC mode", stage_o, S_RUN);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule